// File: doc/BRIEF.md
# Dual-Port Sample Pairing Latch

This block takes the two 8-bit output ports of a ping-pong demultiplexed converter and joins them into one 16-bit word that updates once every two encode cycles. It runs on the encode clock. Inside, a divide-by-two produces a half-rate capture strobe, and the word register loads on the edges where that strobe is high. The free-running divider has no fixed phase relation to the converter's own port toggling, so the same sync pulse that aligns the converter also clears this divider. Once both are cleared on the same edge, port A and port B are captured together in a known order.

A sequencer with four states controls the block. `PL_BYPASS` is the single-port mode: the latch is idle and sync is ignored. `PL_UNSYNCED` means dual mode with no alignment yet. `PL_HOLD` means sync is active and the divider is held. `PL_LOCKED` means the divider runs and capture is enabled. The transitions are as follows. Dropping `dual_mode_i` leads to `PL_BYPASS` from any state. `PL_BYPASS` goes to `PL_UNSYNCED` when dual mode is selected. `PL_UNSYNCED` goes to `PL_HOLD` on sync. `PL_HOLD` goes to `PL_LOCKED` when sync is released. `PL_LOCKED` goes back to `PL_HOLD` on a new sync, and to `PL_UNSYNCED` when the phase-select input changes.

A phase-select input inverts the half-rate strobe. This compensates a board-level swap in which the converter's port loading is shifted by one cycle. Because a change of phase breaks the alignment, the sequencer drops back to `PL_UNSYNCED` and waits for the next sync.

Top module: `sample_pair_latch`

## Requirements
- R1: While `rst_ni` is low, and directly after it rises, `pair_word_o` is 0 and both `pair_valid_o` and `cap_strobe_o` are low.
- R2: With `dual_mode_i` low the latch is disabled. The strobe and valid stay low, the word holds its value, and sync pulses have no effect: after dual mode is selected again, valid and strobe stay low until a sync pulse is applied.
- R3: While `sync_i` is high in dual mode, the divider is held and no capture occurs. Count the edges at which sync is first sampled low after a pulse as edge 1, 2, 3 and so on. With `phase_inv_i` low, `cap_strobe_o` is high before every even-numbered edge, and each such edge is a capture.
- R4: On each capture edge `pair_word_o` loads port A into bits 15:8 and port B into bits 7:0. At all other edges the word holds its value.
- R5: `pair_valid_o` rises at the second capture after sync is released. The first capture primes the latch and is not flagged. Valid then stays high while the sequencer remains locked.
- R6: With `phase_inv_i` high the strobe is inverted. Captures fall on odd-numbered edges from edge 3 onward.
- R7: A change of `phase_inv_i` while locked drops `pair_valid_o` on the next edge and stops capture until a new sync pulse.
- R8: Fed by a ping-pong source that was aligned by the same sync pulse, every valid word holds two consecutive samples with the earlier one in the upper byte. Successive valid words continue the sample sequence with nothing dropped or repeated, whatever the source's phase was before sync.
- R9: A sync pulse while locked clears `pair_valid_o` on the next edge and restarts the alignment sequence of R3 and R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Encode-rate clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dual_mode_i | input | 1 | 1 selects dual-port pairing, 0 selects single-port mode (latch disabled) |
| sync_i | input | 1 | Shared data-sync pulse, active high |
| phase_inv_i | input | 1 | Inverts the half-rate capture strobe |
| port_a_i | input | 8 | Converter port A (earlier sample of a pair) |
| port_b_i | input | 8 | Converter port B (later sample of a pair) |
| pair_word_o | output | 16 | Paired word: port A in 15:8, port B in 7:0 |
| pair_valid_o | output | 1 | The paired word holds an aligned pair |
| cap_strobe_o | output | 1 | Half-rate capture strobe; the next clock edge captures |

## Verification
Suppose the divider's parity is wrong after sync. The strobe then appears one cycle early or late at the first edge after release, and the captured words come out with their bytes out of order or stale, within four edges. A sequencer stuck in the wrong state shows at the ports as valid that rises without a preceding strobe, or as valid that survives a sync, a phase change or single-port mode, one edge after the event. A broken priming rule moves the valid rise by exactly one capture, that is, two edges.

// File: rtl/pairlatch_pkg.sv
package pairlatch_pkg;

    typedef enum logic [1:0] {
        PL_BYPASS   = 2'd0,
        PL_UNSYNCED = 2'd1,
        PL_HOLD     = 2'd2,
        PL_LOCKED   = 2'd3
    } pl_state_e;

endpackage

// File: rtl/pl_sequencer.sv
module pl_sequencer
    import pairlatch_pkg::*;
(
    input  logic      clk_i,
    input  logic      rst_ni,
    input  logic      dual_mode_i,
    input  logic      sync_i,
    input  logic      phase_inv_i,
    output pl_state_e state_o,
    output logic      inv_changed_o,
    output logic      stay_locked_o
);

    pl_state_e state_q;
    pl_state_e state_d;
    logic      inv_q;
    logic      inv_changed;

    assign inv_changed = phase_inv_i ^ inv_q;

    always_comb begin
        state_d = state_q;
        if (!dual_mode_i) begin
            state_d = PL_BYPASS;
        end else begin
            unique case (state_q)
                PL_BYPASS:   state_d = PL_UNSYNCED;
                PL_UNSYNCED: state_d = sync_i ? PL_HOLD : PL_UNSYNCED;
                PL_HOLD:     state_d = sync_i ? PL_HOLD : PL_LOCKED;
                PL_LOCKED: begin
                    if (sync_i) begin
                        state_d = PL_HOLD;
                    end else if (inv_changed) begin
                        state_d = PL_UNSYNCED;
                    end else begin
                        state_d = PL_LOCKED;
                    end
                end
                default:     state_d = PL_BYPASS;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= PL_BYPASS;
            inv_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            inv_q   <= phase_inv_i;
        end
    end

    always_comb begin
        state_o       = state_q;
        inv_changed_o = inv_changed;
        stay_locked_o = (state_d == PL_LOCKED) && (state_q == PL_LOCKED);
    end

endmodule

// File: rtl/pl_halfrate_div.sv
module pl_halfrate_div (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_i,
    input  logic run_i,
    output logic div_o
);

    logic div_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            div_q <= 1'b0;
        end else if (sync_i || !run_i) begin
            div_q <= 1'b0;
        end else begin
            div_q <= ~div_q;
        end
    end

    assign div_o = div_q;

endmodule

// File: rtl/pl_capture.sv
module pl_capture #(
    parameter int PORT_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                strobe_i,
    input  logic                stay_locked_i,
    input  logic [PORT_W-1:0]   port_a_i,
    input  logic [PORT_W-1:0]   port_b_i,
    output logic [2*PORT_W-1:0] word_o,
    output logic                valid_o
);

    localparam int WORD_W = 2 * PORT_W;

    logic [WORD_W-1:0] word_q;
    logic              primed_q;
    logic              valid_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            word_q <= '0;
        end else if (strobe_i) begin
            word_q <= {port_a_i, port_b_i};
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            primed_q <= 1'b0;
            valid_q  <= 1'b0;
        end else if (!stay_locked_i) begin
            primed_q <= 1'b0;
            valid_q  <= 1'b0;
        end else if (strobe_i) begin
            primed_q <= 1'b1;
            valid_q  <= primed_q;
        end
    end

    assign word_o  = word_q;
    assign valid_o = valid_q;

endmodule

// File: rtl/sample_pair_latch.sv
module sample_pair_latch
    import pairlatch_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                dual_mode_i,
    input  logic                sync_i,
    input  logic                phase_inv_i,
    input  logic [PORT_W-1:0]   port_a_i,
    input  logic [PORT_W-1:0]   port_b_i,
    output logic [2*PORT_W-1:0] pair_word_o,
    output logic                pair_valid_o,
    output logic                cap_strobe_o
);

    pl_state_e state;
    logic      inv_changed;
    logic      stay_locked;
    logic      div;
    logic      div_run;
    logic      strobe;

    pl_sequencer u_seq (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .dual_mode_i   (dual_mode_i),
        .sync_i        (sync_i),
        .phase_inv_i   (phase_inv_i),
        .state_o       (state),
        .inv_changed_o (inv_changed),
        .stay_locked_o (stay_locked)
    );

    assign div_run = (state == PL_HOLD) || (state == PL_LOCKED);

    pl_halfrate_div u_div (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .sync_i (sync_i),
        .run_i  (div_run),
        .div_o  (div)
    );

    always_comb begin
        strobe = (state == PL_LOCKED) && dual_mode_i && !sync_i &&
                 !inv_changed && (div ^ phase_inv_i);
    end

    pl_capture #(.PORT_W(PORT_W)) u_cap (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .strobe_i      (strobe),
        .stay_locked_i (stay_locked),
        .port_a_i      (port_a_i),
        .port_b_i      (port_b_i),
        .word_o        (pair_word_o),
        .valid_o       (pair_valid_o)
    );

    assign cap_strobe_o = strobe;

endmodule

// File: rtl/pl_checker.sv
module pl_checker #(
    parameter int PORT_W = 8
) (
    input logic                clk_i,
    input logic                rst_ni,
    input logic                dual_mode_i,
    input logic                sync_i,
    input logic                phase_inv_i,
    input logic [2*PORT_W-1:0] pair_word_o,
    input logic                pair_valid_o,
    input logic                cap_strobe_o
);

    // R2: single-port mode idles the latch
    a_r2_single_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !dual_mode_i |=> (!pair_valid_o && !cap_strobe_o));

    // R3: capture strobe is half rate, never two cycles in a row
    a_r3_half_rate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cap_strobe_o |=> !cap_strobe_o);

    // R4: the word only changes on a capture edge
    a_r4_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !cap_strobe_o |=> $stable(pair_word_o));

    // R5: valid can only rise on a capture edge
    a_r5_valid_on_capture: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pair_valid_o) |-> $past(cap_strobe_o));

    // R7: a phase change removes the alignment
    a_r7_phase_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (phase_inv_i != $past(phase_inv_i)) |=> !pair_valid_o);

    // R9: sync clears valid
    a_r9_sync_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sync_i && dual_mode_i) |=> !pair_valid_o);

endmodule

bind sample_pair_latch pl_checker #(.PORT_W(PORT_W)) u_pl_checker (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .dual_mode_i  (dual_mode_i),
    .sync_i       (sync_i),
    .phase_inv_i  (phase_inv_i),
    .pair_word_o  (pair_word_o),
    .pair_valid_o (pair_valid_o),
    .cap_strobe_o (cap_strobe_o)
);

// File: tb/tb_sample_pair_latch.sv
`timescale 1ns/1ps
module tb_sample_pair_latch;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        dual = 1'b0;
    logic        sync = 1'b0;
    logic        inv = 1'b0;
    logic [7:0]  pa = 8'h00;
    logic [7:0]  pb = 8'h00;
    logic [15:0] word;
    logic        valid;
    logic        strobe;

    always #2 clk = ~clk;

    sample_pair_latch dut (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .dual_mode_i  (dual),
        .sync_i       (sync),
        .phase_inv_i  (inv),
        .port_a_i     (pa),
        .port_b_i     (pb),
        .pair_word_o  (word),
        .pair_valid_o (valid),
        .cap_strobe_o (strobe)
    );

    int vectors = 0;
    int miscompares = 0;

    // reference model: 0 off, 1 waiting, 2 held, 3 running
    int          m_mode = 0;
    int          m_edge = 0;
    int          m_caps = 0;
    bit          m_valid = 0;
    bit          m_pinv = 0;
    bit          m_capnow = 0;
    logic [15:0] m_word = 16'h0;

    // ping-pong source model
    bit          src_div = 0;
    bit          src_swap = 0;
    logic [7:0]  src_smp = 8'h00;

    // continuity tracking for R8
    bit          have_last = 0;
    logic [7:0]  last_low = 8'h00;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp,
                       input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic cycle();
        @(posedge clk);
        #1;
        m_capnow = 0;
        if (!rst_n) begin
            m_mode = 0; m_valid = 0; m_caps = 0; m_word = 16'h0; m_edge = 0;
        end else if (!dual) begin
            m_mode = 0; m_valid = 0; m_caps = 0;
        end else begin
            case (m_mode)
                0: m_mode = 1;
                1: if (sync) m_mode = 2;
                2: if (!sync) begin m_mode = 3; m_edge = 1; end
                default: begin
                    if (sync) begin
                        m_mode = 2; m_valid = 0; m_caps = 0;
                    end else if (inv != m_pinv) begin
                        m_mode = 1; m_valid = 0; m_caps = 0;
                    end else begin
                        m_edge++;
                        if (inv ? (m_edge % 2 == 1) : (m_edge % 2 == 0)) begin
                            m_word = {pa, pb};
                            m_caps++;
                            m_capnow = 1;
                            if (m_caps >= 2) m_valid = 1;
                        end
                    end
                end
            endcase
        end
        m_pinv = rst_n ? inv : 1'b0;
        // source: load one port per edge, divider forced by sync
        if (src_div == 0) pa = src_smp; else pb = src_smp;
        src_smp = src_smp + 8'd1;
        src_div = sync ? ~src_swap : ~src_div;
        @(negedge clk);
        chk("R5", {31'b0, valid}, {31'b0, m_valid}, "pair_valid");
        chk(inv ? "R6" : "R3", {31'b0, strobe},
            {31'b0, (m_mode == 3) && (((m_edge & 1) != 0) ^ inv)}, "cap_strobe");
        chk("R4", {16'b0, word}, {16'b0, m_word}, "pair_word");
        if (!m_valid) begin
            have_last = 0;
        end else if (m_capnow) begin
            chk("R8", {24'b0, word[7:0]}, {24'b0, word[15:8] + 8'd1}, "pair order");
            if (have_last)
                chk("R8", {24'b0, word[15:8]}, {24'b0, last_low + 8'd1}, "continuity");
            last_low = word[7:0];
            have_last = 1;
        end
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cycle();
    endtask

    task automatic pulse_sync(input int len);
        sync = 1'b1;
        run(len);
        sync = 1'b0;
    endtask

    initial begin
        #400000;
        miscompares++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        src_div = 1'($urandom % 2);
        src_smp = 8'($urandom);
        run(3);
        // R1 during reset
        chk("R1", {15'b0, word, valid}, 32'h0, "reset outputs");
        rst_n = 1'b1;
        run(1);
        chk("R1", {15'b0, word, valid, strobe}, 32'h0, "after reset");

        // R2: single-port mode ignores sync
        pulse_sync(2);
        run(6);
        chk("R2", {30'b0, valid, strobe}, 32'h0, "single mode idle");
        dual = 1'b1;
        run(8);
        chk("R2", {30'b0, valid, strobe}, 32'h0, "no lock without sync");

        // aligned run, normal phase
        pulse_sync(1);
        run(30);
        chk("R5", {31'b0, valid}, 32'h1, "locked valid");

        // R9: resync while locked
        sync = 1'b1;
        cycle();
        chk("R9", {31'b0, valid}, 32'h0, "valid after resync");
        run(1);
        sync = 1'b0;
        run(20);

        // R7: phase change without sync
        inv = 1'b1;
        cycle();
        chk("R7", {31'b0, valid}, 32'h0, "valid after phase change");
        run(10);
        chk("R7", {30'b0, valid, strobe}, 32'h0, "no capture until sync");

        // board swap compensated by inversion
        src_swap = 1'b1;
        pulse_sync(2);
        run(30);
        chk("R6", {31'b0, valid}, 32'h1, "inverted phase locks");

        // random phases and sync lengths
        for (int k = 0; k < 30; k++) begin
            src_swap = 1'($urandom % 2);
            inv = src_swap;
            if (k % 7 == 3) src_div = 1'($urandom % 2);
            pulse_sync(1 + int'($urandom % 3));
            run(12 + int'($urandom % 30));
            chk("R8", {31'b0, valid}, 32'h1, "locked after random sync");
        end

        // R2: dropping dual mode while locked
        dual = 1'b0;
        cycle();
        chk("R2", {30'b0, valid, strobe}, 32'h0, "drop to single mode");
        run(5);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule